// File: doc/BRIEF.md
# Dual-Bank Reference Code Register File

This block stores the digital codes for a row of programmable reference channels. Each channel holds one code in each of two complete banks. A host loads the codes through a simple write port: a strobe, a bank bit, a channel address and a data byte. That port stands in for whatever serial front end sits upstream. Any stored code can be read back at once on a separate read port.

A bank-select pin, which may be asynchronous to the clock, picks which bank drives the channel code outputs. The pin passes through a two-flop synchronizer. The selected bank then reaches every code output through a single output register, so the whole set of outputs moves from one curve to the other on the same clock edge.

Every channel also has an output-enable flag. The flag stays low from reset, so the analog buffer that follows stays high-impedance. It goes high once that channel has been written in either bank, and only a reset clears it. The channels form an upper group (1 to 7) and a lower group (8 to 14).

Top module: `gamma_code_bank`

## Requirements
- R1: While reset is high at a rising edge, every code in both banks, every output-enable bit, the code outputs and `active_bank` are cleared to zero. Zero on `active_bank` means bank A.
- R2: A write (`wr_en`=1 with `wr_addr` in 1..14) stores `wr_data` into the addressed channel of the addressed bank. The stored value appears on `rd_data` straight after that rising edge, because the read path is combinational.
- R3: A change on `bank_sel_in` reaches `active_bank` and all 14 code outputs together on the third rising edge after the change: two synchronizer flops, then the output register.
- R4: A write to the bank currently shown appears on `code_out` one rising edge after the edge that performs the write.
- R5: A write to the bank not currently shown leaves `code_out` unchanged.
- R6: A channel's bit in `out_en` goes to 1 on the same edge that its first written code can reach `code_out`. This happens after a write to that channel in either bank. The bit stays at 1 until reset.
- R7: A write with `wr_addr` equal to 0 or above 14 changes no code and no enable bit. A read with such an address returns zero.
- R8: Channel n (1..14) sits at `code_out[n-1]` and `out_en[n-1]`. Channels 1..7 form the upper group at the low indices, and channels 8..14 form the lower group.
- R9: The value 0 on `wr_bank`, `rd_bank`, `bank_sel_in` and `active_bank` means bank A, and 1 means bank B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_bank | input | 1 | Bank written (0 = A, 1 = B) |
| wr_addr | input | 4 | Channel written, 1..14 valid |
| wr_data | input | 8 | Code to store |
| bank_sel_in | input | 1 | Asynchronous bank choice for the outputs |
| rd_bank | input | 1 | Bank read back |
| rd_addr | input | 4 | Channel read back |
| rd_data | output | 8 | Stored code, zero for an invalid address |
| code_out | output | 14x8 | Registered per-channel codes from the active bank |
| out_en | output | 14 | Per-channel enable; low means high-impedance |
| active_bank | output | 1 | Bank currently driving `code_out` |

## Verification
The bench builds the block with its default parameters: 14 channels, 8-bit codes, a 4-bit address and a two-stage synchronizer. With a 4-bit address, both invalid extremes (0 and 15) can be driven next to every valid channel, so the ignore-and-read-zero rule is exercised at both ends. With only two synchronizer stages, the three-edge bank-switch latency can be pinned to an exact cycle. Random writes are mixed with bank flips, so writes land both on the bank being shown and on the hidden one. These writes also arrive in the cycles where the synchronized selection is changing.

// File: rtl/gcb_pkg.sv
package gcb_pkg;

  // Bank encoding used on every bank-related port.
  typedef enum logic {
    BANK_A = 1'b0,
    BANK_B = 1'b1
  } bank_e;

  localparam int NUM_BANKS = 2;

endpackage

// File: rtl/gcb_sync.sv
module gcb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain <= {chain[STAGES-2:0], d_async};
    end
  end

  assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/gcb_code_store.sv
module gcb_code_store #(
  parameter int NUM_CH = 14,
  parameter int CODE_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [CODE_W-1:0]              wr_data,
  output logic [NUM_CH-1:0][CODE_W-1:0]  codes
);

  logic [NUM_CH-1:0] hit;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
      assign hit[c] = wr_en && (wr_addr == ADDR_W'(c + 1));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      codes <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (hit[c]) codes[c] <= wr_data;
      end
    end
  end

  AST_ONE_SLOT_WRITTEN: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit)); // R2

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(1)) |=> (codes[0] == $past(wr_data))); // R2

endmodule

// File: rtl/gcb_en_track.sv
module gcb_en_track #(
  parameter int NUM_CH = 14,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [NUM_CH-1:0] en_q
);

  logic addr_ok;
  assign addr_ok = (wr_addr != '0) && (wr_addr <= ADDR_W'(NUM_CH));

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (wr_en && wr_addr == ADDR_W'(c + 1)) en_q[c] <= 1'b1;
      end
    end
  end

  AST_EN_STICKY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((en_q & $past(en_q)) == $past(en_q))); // R6

  AST_BAD_ADDR_NO_EN: assert property (@(posedge clk) disable iff (rst)
    (!wr_en || !addr_ok) |=> $stable(en_q)); // R7

endmodule

// File: rtl/gcb_out_stage.sv
module gcb_out_stage #(
  parameter int NUM_CH = 14,
  parameter int CODE_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          sel,
  input  logic [NUM_CH-1:0][CODE_W-1:0] codes_a,
  input  logic [NUM_CH-1:0][CODE_W-1:0] codes_b,
  input  logic [NUM_CH-1:0]             en_in,
  output logic [NUM_CH-1:0][CODE_W-1:0] code_q,
  output logic [NUM_CH-1:0]             en_q,
  output logic                          bank_q
);

  import gcb_pkg::*;

  logic [NUM_CH-1:0][CODE_W-1:0] pick;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_mux
      assign pick[c] = (bank_e'(sel) == BANK_B) ? codes_b[c] : codes_a[c];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      en_q   <= '0;
      bank_q <= 1'b0;
    end else begin
      code_q <= pick;
      en_q   <= en_in;
      bank_q <= sel;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (en_q == '0 && code_q == '0 && bank_q == 1'b0)); // R1

  AST_BANK_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (bank_q == $past(sel))); // R3

endmodule

// File: rtl/gamma_code_bank.sv
module gamma_code_bank #(
  parameter int NUM_CH      = 14,
  parameter int CODE_W      = 8,
  parameter int ADDR_W      = $clog2(NUM_CH + 1),
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic                          wr_bank,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [CODE_W-1:0]             wr_data,
  input  logic                          bank_sel_in,
  input  logic                          rd_bank,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic [CODE_W-1:0]             rd_data,
  output logic [NUM_CH-1:0][CODE_W-1:0] code_out,
  output logic [NUM_CH-1:0]             out_en,
  output logic                          active_bank
);

  import gcb_pkg::*;

  logic                          sel_sync;
  logic [NUM_CH-1:0][CODE_W-1:0] bank_codes [NUM_BANKS];
  logic [NUM_CH-1:0]             en_flags;
  logic                          rd_ok;

  gcb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (bank_sel_in),
    .q_sync  (sel_sync)
  );

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      gcb_code_store #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en && (wr_bank == 1'(b))),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .codes   (bank_codes[b])
      );
    end
  endgenerate

  gcb_en_track #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_en (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .en_q    (en_flags)
  );

  gcb_out_stage #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .sel     (sel_sync),
    .codes_a (bank_codes[0]),
    .codes_b (bank_codes[1]),
    .en_in   (en_flags),
    .code_q  (code_out),
    .en_q    (out_en),
    .bank_q  (active_bank)
  );

  // Combinational readback straight from the register arrays.
  assign rd_ok = (rd_addr != '0) && (rd_addr <= ADDR_W'(NUM_CH));

  always_comb begin
    rd_data = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_addr == ADDR_W'(c + 1)) begin
        rd_data = (bank_e'(rd_bank) == BANK_B) ? bank_codes[1][c] : bank_codes[0][c];
      end
    end
  end

  AST_RD_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (rst)
    !rd_ok |-> (rd_data == '0)); // R7

  AST_EN_WITHOUT_WRITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(en_flags)); // R6

endmodule

// File: tb/sim_gamma_code_bank.sv
module sim_gamma_code_bank;

  localparam int NCH = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, wr_bank = 1'b0, bank_sel_in = 1'b0, rd_bank = 1'b0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [NCH-1:0][7:0] code_out;
  logic [NCH-1:0] out_en;
  logic active_bank;

  always #4 clk = ~clk;

  gamma_code_bank u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .wr_data(wr_data), .bank_sel_in(bank_sel_in), .rd_bank(rd_bank),
    .rd_addr(rd_addr), .rd_data(rd_data), .code_out(code_out),
    .out_en(out_en), .active_bank(active_bank)
  );

  int checks = 0;
  int errors = 0;
  bit armed = 0;
  bit done = 0;

  // Behavioural reference state
  logic [7:0] mem [2][16];
  bit en_m [16];
  bit s1 = 0, s2 = 0;
  logic [NCH-1:0][7:0] exp_codes = '0;
  logic [NCH-1:0] exp_en = '0;
  bit exp_bank = 0;

  task automatic check(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst) begin
      for (int b = 0; b < 2; b++)
        for (int a = 0; a < 16; a++) mem[b][a] = 8'h00;
      for (int a = 0; a < 16; a++) en_m[a] = 0;
      s1 = 0; s2 = 0; exp_codes = '0; exp_en = '0; exp_bank = 0;
      armed = 1;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        exp_codes[c] = mem[s2][c+1];
        exp_en[c] = en_m[c+1];
      end
      exp_bank = s2;
      s2 = s1;
      s1 = bank_sel_in;
      if (wr_en && wr_addr >= 1 && wr_addr <= NCH) begin
        mem[wr_bank][wr_addr] = wr_data;
        en_m[wr_addr] = 1;
      end
    end
    @(negedge clk);
    if (armed) begin
      logic [7:0] exp_rd;
      exp_rd = (rd_addr >= 1 && rd_addr <= NCH) ? mem[rd_bank][rd_addr] : 8'h00;
      check(code_out == exp_codes, "R3 R4 R5 R8 code_out", 128'(code_out), 128'(exp_codes));
      check(out_en == exp_en, "R6 R8 out_en", 128'(out_en), 128'(exp_en));
      check(active_bank == exp_bank, "R3 R9 active_bank", 128'(active_bank), 128'(exp_bank));
      check(rd_data == exp_rd, "R2 R7 rd_data", 128'(rd_data), 128'(exp_rd));
    end
  endtask

  task automatic wr(input bit b, input int a, input int d);
    wr_en = 1; wr_bank = b; wr_addr = 4'(a); wr_data = 8'(d);
    tick();
    wr_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
      $finish;
    end
  end

  initial begin
    repeat (4) tick();
    // R1: reset state
    check(code_out == '0, "R1 codes", 128'(code_out), 0);
    check(out_en == '0, "R1 enables", 128'(out_en), 0);
    check(active_bank == 1'b0, "R1 bank A", 128'(active_bank), 0);
    rst = 0;
    tick();

    // R2, R4, R6: write ch3 in shown bank A
    rd_bank = 0; rd_addr = 4'd3;
    wr(0, 3, 8'h5A);
    check(rd_data == 8'h5A, "R2 readback", 128'(rd_data), 128'h5A);
    check(code_out[2] == 8'h00, "R4 not yet", 128'(code_out[2]), 0);
    tick();
    check(code_out[2] == 8'h5A, "R4 shown", 128'(code_out[2]), 128'h5A);
    check(out_en[2] == 1'b1, "R6 enable", 128'(out_en[2]), 1);

    // R5, R9: write hidden bank B
    wr(1, 3, 8'hC3);
    tick(); tick();
    check(code_out[2] == 8'h5A, "R5 hidden write", 128'(code_out[2]), 128'h5A);
    rd_bank = 1;
    tick();
    check(rd_data == 8'hC3, "R9 bank B readback", 128'(rd_data), 128'hC3);

    // R3: switch to bank B, latency three edges
    bank_sel_in = 1;
    tick(); tick();
    check(active_bank == 1'b0, "R3 still A", 128'(active_bank), 0);
    tick();
    check(active_bank == 1'b1, "R3 now B", 128'(active_bank), 1);
    check(code_out[2] == 8'hC3, "R3 code B", 128'(code_out[2]), 128'hC3);

    // R7: invalid addresses ignored
    wr(0, 0, 8'hFF); wr(1, 15, 8'hFF);
    rd_addr = 4'd15;
    tick(); tick();
    check(rd_data == 8'h00, "R7 read 15", 128'(rd_data), 0);
    check(out_en == 14'h0004, "R7 enables kept", 128'(out_en), 128'h4);

    // R6, R8: hidden-bank writes at group edges set enables
    wr(0, 1, 8'h11); wr(0, 14, 8'hEE); wr(0, 7, 8'h77); wr(0, 8, 8'h88);
    tick();
    check(out_en == 14'h20C5, "R6 R8 enables", 128'(out_en), 128'h20C5);
    check(code_out[0] == 8'h00, "R5 ch1 hidden", 128'(code_out[0]), 0);
    bank_sel_in = 0;
    tick(); tick(); tick();
    check(code_out[0] == 8'h11 && code_out[13] == 8'hEE, "R8 ch1 ch14",
          128'({code_out[0], code_out[13]}), 128'h11EE);
    check(code_out[6] == 8'h77 && code_out[7] == 8'h88, "R8 group edge",
          128'({code_out[6], code_out[7]}), 128'h7788);

    // Random traffic compared against the model every cycle
    for (int i = 0; i < 3000; i++) begin
      wr_en = 1'($urandom_range(0, 1));
      wr_bank = 1'($urandom_range(0, 1));
      wr_addr = 4'($urandom_range(0, 15));
      wr_data = 8'($urandom_range(0, 255));
      rd_bank = 1'($urandom_range(0, 1));
      rd_addr = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 9) == 0) bank_sel_in = ~bank_sel_in;
      tick();
    end
    wr_en = 0;

    // R1, R6: reset clears enables
    rst = 1;
    tick();
    rst = 0;
    check(out_en == '0, "R6 cleared by reset", 128'(out_en), 0);
    check(code_out == '0, "R1 codes after reset", 128'(code_out), 0);
    tick();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule